// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two 3×3 signed integer matrices, C = A × B, on a square grid of nine identical multiply-accumulate cells. Each cell keeps its own running sum in place. On every run cycle, A operands move one cell to the right and B operands move one cell down. A skew feeder presents each row of A at the left edge and each column of B at the top edge. Row i and column j start i and j cycles late. Every boundary slot outside a row's or column's valid window carries zero. As a result, the operands that meet in cell (i,j) always share the same inner index, and every stray product is zero. Each matrix element enters the grid exactly once. All reuse comes from passing operands between neighbours.

Software-side logic first writes both matrices through a write port, one element per cycle, addressed in row-major order. It then pulses start. The control state machine has three states. IDLE waits for start. On start it takes the IDLE→RUN transition: it clears every accumulator and forwarding register and copies the written matrices into private run copies. RUN lasts 3N−2 cycles (7 for N = 3). When the run-cycle counter reaches its last value, the RUN→DONE transition is taken. DONE lasts one cycle, raises done, and then takes the DONE→IDLE transition. A combinational read port returns any accumulator by row-major index.

Top module: `osmm_array`

## Requirements
- R1: A write with wr_en high stores wr_data into element wr_idx (row-major, index = 3·row + col) of A when wr_sel = 0 and of B when wr_sel = 1. A write with wr_idx ≥ 9 changes nothing.
- R2: A start pulse in IDLE makes busy high in the next cycle, and at that point all nine accumulators read 0.
- R3: busy stays high for exactly 7 cycles. Then done is high for exactly one cycle while busy is low. After that both are low.
- R4: start is ignored while busy or done is high: the run length and the results are unaffected, and no new run begins.
- R5: After done, read index 3·i + j returns c_ij = Σk a_ik·b_kj. For A = B = [[3,4,2],[2,5,3],[3,2,5]], this gives [[23,36,28],[25,39,34],[28,32,37]].
- R6: The top-left accumulator reads 9, 17 and 23 after run cycles 1, 2 and 3 for the R5 vector. After run cycle 1, every other accumulator still reads 0.
- R7: Writes made during a run do not change that run's results. The next start uses the new values.
- R8: rd_data is 0 for rd_idx ≥ 9.
- R9: Outside RUN, results hold their values until the next accepted start.
- R10: Arithmetic is two's-complement signed. Extreme inputs (−128, 127) give exact sums in the 20-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Element write strobe |
| wr_sel | input | 1 | 0 selects A, 1 selects B |
| wr_idx | input | 4 | Row-major element index |
| wr_data | input | 8 | Signed element value |
| start | input | 1 | Begin a run (accepted in IDLE only) |
| busy | output | 1 | High during RUN |
| done | output | 1 | One-cycle completion flag |
| rd_idx | input | 4 | Row-major result index |
| rd_data | output | 20 | Signed accumulator selected by rd_idx |

## Verification
A start driven before rising edge E0 shows busy at the next falling edge. The top-left sum after run cycle t is visible t falling edges after that. Done first appears 7 falling edges after busy rose, and the final products are readable from that edge on. The bench drives every input on falling edges and reads the combinational result port a few picoseconds later, before the next rising edge. It counts falling edges with busy high, so each expected value is compared in exactly the cycle it is due. Random matrices from a fixed seed are checked against a bench-side matrix product, alongside the directed vector, signed extremes, mid-run writes and mid-run start pulses.

// File: rtl/osmm_pkg.sv
package osmm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } osmm_state_e;
endpackage

// File: rtl/osmm_ctrl.sv
module osmm_ctrl
    import osmm_pkg::*;
#(
    parameter int N  = 3,
    parameter int TW = $clog2(3*N-2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          clr,
    output logic [TW-1:0] tick
);
    localparam logic [TW-1:0] LAST = TW'(3*N-3);

    osmm_state_e state_q, state_d;

    // State register and run-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick    <= '0;
        end else begin
            state_q <= state_d;
            if (clr)
                tick <= '0;
            else if (state_q == ST_RUN && tick != LAST)
                tick <= tick + 1'b1;
        end
    end

    // Transitions: IDLE->RUN on start, RUN->DONE at last tick, DONE->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (tick == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_RUN);
        done = (state_q == ST_DONE);
        clr  = (state_q == ST_IDLE) && start;
    end

    // R3: done is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: done only follows the final run cycle
    assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && $past(tick) == LAST));
    // R4: start during a run never restarts it
    assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

// File: rtl/osmm_skew.sv
module osmm_skew #(
    parameter int N  = 3,
    parameter int DW = 8,
    parameter int IW = $clog2(N*N+1),
    parameter int TW = $clog2(3*N-2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 snap,
    input  logic                 run,
    input  logic [TW-1:0]        tick,
    output logic signed [DW-1:0] left_a [N],
    output logic signed [DW-1:0] top_b  [N]
);
    localparam int            CELLS   = N*N;
    localparam logic [IW-1:0] CELLS_I = IW'(CELLS);

    logic signed [DW-1:0] held_a [CELLS];
    logic signed [DW-1:0] held_b [CELLS];
    logic signed [DW-1:0] run_a  [CELLS];
    logic signed [DW-1:0] run_b  [CELLS];

    // Write port and run snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < CELLS; k++) begin
                held_a[k] <= '0;
                held_b[k] <= '0;
                run_a[k]  <= '0;
                run_b[k]  <= '0;
            end
        end else begin
            if (wr_en && wr_idx < CELLS_I) begin
                if (!wr_sel) held_a[wr_idx] <= wr_data;
                else         held_b[wr_idx] <= wr_data;
            end
            if (snap) begin
                for (int k = 0; k < CELLS; k++) begin
                    run_a[k] <= held_a[k];
                    run_b[k] <= held_b[k];
                end
            end
        end
    end

    // Staggered boundary: lane r carries inner index (tick - r), zero outside
    always_comb begin
        for (int r = 0; r < N; r++) begin
            int m;
            logic [IW-1:0] ia;
            logic [IW-1:0] ib;
            m  = int'(tick) - r;
            ia = IW'(r*N + m);
            ib = IW'(m*N + r);
            left_a[r] = '0;
            top_b[r]  = '0;
            if (run && m >= 0 && m < N) begin
                left_a[r] = run_a[ia];
                top_b[r]  = run_b[ib];
            end
        end
    end
endmodule

// File: rtl/osmm_pe.sv
module osmm_pe #(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] a_in,
    input  logic signed [DW-1:0] b_in,
    output logic signed [DW-1:0] a_out,
    output logic signed [DW-1:0] b_out,
    output logic signed [AW-1:0] acc
);
    logic signed [2*DW-1:0] prod;

    always_comb prod = a_in * b_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            a_out <= '0;
            b_out <= '0;
        end else if (clr) begin
            acc   <= '0;
            a_out <= '0;
            b_out <= '0;
        end else if (en) begin
            acc   <= acc + AW'(prod);
            a_out <= a_in;
            b_out <= b_in;
        end
    end
endmodule

// File: rtl/osmm_array.sv
module osmm_array
    import osmm_pkg::*;
#(
    parameter int N  = 3,
    parameter int DW = 8,
    parameter int AW = 20,
    parameter int IW = $clog2(N*N+1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [AW-1:0] rd_data
);
    localparam int            TW      = $clog2(3*N-2);
    localparam int            CELLS   = N*N;
    localparam logic [IW-1:0] CELLS_I = IW'(CELLS);

    logic          clr;
    logic [TW-1:0] tick;

    logic signed [DW-1:0] a_h [N][N+1];
    logic signed [DW-1:0] b_v [N+1][N];
    logic signed [DW-1:0] left_a [N];
    logic signed [DW-1:0] top_b  [N];
    logic signed [AW-1:0] acc_m  [CELLS];

    osmm_ctrl #(.N(N), .TW(TW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .clr(clr), .tick(tick)
    );

    osmm_skew #(.N(N), .DW(DW), .IW(IW), .TW(TW)) skew_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .snap(clr), .run(busy), .tick(tick),
        .left_a(left_a), .top_b(top_b)
    );

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign a_h[g][0] = left_a[g];
        assign b_v[0][g] = top_b[g];
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            osmm_pe #(.DW(DW), .AW(AW)) pe_i (
                .clk(clk), .rst_n(rst_n), .clr(clr), .en(busy),
                .a_in(a_h[r][c]), .b_in(b_v[r][c]),
                .a_out(a_h[r][c+1]), .b_out(b_v[r+1][c]),
                .acc(acc_m[r*N+c])
            );
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx < CELLS_I) rd_data = acc_m[rd_idx];
    end

    // Checker views of the whole grid
    logic [CELLS*AW-1:0] acc_flat;
    logic                any_nz;
    always_comb begin
        any_nz = 1'b0;
        for (int k = 0; k < CELLS; k++) begin
            acc_flat[k*AW +: AW] = acc_m[k];
            if (acc_m[k] != '0) any_nz = 1'b1;
        end
    end

    // R2: a run opens with every accumulator cleared
    assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !any_nz);
    // R9: results hold outside a run unless a start is accepted
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && !done)) |=> $stable(acc_flat));
endmodule

// File: tb/osmm_array_tb_top.sv
`timescale 1ns/1ps
module osmm_array_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0, wr_sel = 1'b0, start = 1'b0;
    logic [3:0]         wr_idx = '0, rd_idx = '0;
    logic signed [7:0]  wr_data = '0;
    logic               busy, done;
    logic signed [19:0] rd_data;

    int checks = 0, errors = 0;
    int am [9];
    int bm [9];
    int expc [9];

    osmm_array dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, output int v);
        rd_idx = 4'(idx);
        #0.01;
        v = int'(rd_data);
    endtask

    task automatic wr(input bit sel, input int idx, input int val);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 4'(idx); wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_all();
        for (int k = 0; k < 9; k++) begin
            wr(1'b0, k, am[k]);
            wr(1'b1, k, bm[k]);
        end
    endtask

    function automatic int cval(input int i, input int j);
        int s = 0;
        for (int k = 0; k < 3; k++) s += am[i*3+k] * bm[k*3+j];
        return s;
    endfunction

    // One run; probe=top-left trace, poke=start and write during the run
    task automatic run_check(input string tag, input bit probe, input bit poke);
        int cnt, v;
        for (int k = 0; k < 9; k++) expc[k] = cval(k/3, k%3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R2 busy ", tag}, int'(busy), 1);
        v = 0;
        for (int k = 0; k < 9; k++) begin
            int t;
            rd(k, t);
            if (t != 0) v++;
        end
        chk({"R2 cleared ", tag}, v, 0);
        cnt = 0;
        while (busy === 1'b1 && cnt < 40) begin
            cnt++;
            @(negedge clk);
            if (probe && cnt <= 3) begin
                rd(0, v);
                chk($sformatf("R6 top-left tick %0d", cnt), v, (cnt == 1) ? 9 : (cnt == 2) ? 17 : 23);
                if (cnt == 1) begin
                    int nz = 0;
                    for (int k = 1; k < 9; k++) begin
                        int t;
                        rd(k, t);
                        if (t != 0) nz++;
                    end
                    chk("R6 others zero after tick 1", nz, 0);
                end
            end
            if (poke && cnt == 2) begin
                start = 1'b1;
                wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 4'd0; wr_data = 8'sd77;
            end
            if (poke && cnt == 3) begin
                start = 1'b0; wr_en = 1'b0;
            end
        end
        chk({"R3 run length ", tag}, cnt, 7);
        chk({"R3 done high ", tag}, int'(done), 1);
        start = 1'b1;              // start while done: must be ignored (R4)
        @(negedge clk);
        start = 1'b0;
        chk({"R3 done pulse ends ", tag}, int'(done), 0);
        chk({"R4 no restart ", tag}, int'(busy), 0);
        for (int k = 0; k < 9; k++) begin
            rd(k, v);
            chk($sformatf("R5 c%0d %s", k, tag), v, expc[k]);
        end
        if (poke) am[0] = 77;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        logic signed [7:0] r8;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset busy", int'(busy), 0);
        chk("R3 reset done", int'(done), 0);
        rd(0, v); chk("R9 reset result", v, 0);

        // R5/R6 directed vector
        am = '{3,4,2, 2,5,3, 3,2,5};
        bm = am;
        load_all();
        run_check("vector", 1'b1, 1'b0);
        chk("R5 vector c11", expc[4], 39);

        // R8 out-of-range reads
        rd(9, v);  chk("R8 idx 9", v, 0);
        rd(15, v); chk("R8 idx 15", v, 0);

        // R9 hold in idle
        repeat (5) @(negedge clk);
        rd(8, v); chk("R9 held c22", v, 37);

        // R1 asymmetric A/B and ignored out-of-range writes
        am = '{1,0,0, 0,2,0, 0,0,3};
        bm = '{1,2,3, 4,5,6, 7,8,9};
        load_all();
        wr(1'b0, 9, 55);
        wr(1'b1, 14, -9);
        run_check("R1 select", 1'b0, 1'b0);

        // R4/R7 start and write during run
        run_check("R7 midrun", 1'b0, 1'b1);
        run_check("R7 next run", 1'b0, 1'b0);

        // R10 signed extremes
        for (int k = 0; k < 9; k++) begin am[k] = -128; bm[k] = -128; end
        load_all();
        run_check("R10 neg", 1'b0, 1'b0);
        for (int k = 0; k < 9; k++) bm[k] = 127;
        load_all();
        run_check("R10 mixed", 1'b0, 1'b0);

        // Random matrices
        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < 9; k++) begin
                r8 = 8'($urandom());
                am[k] = int'(r8);
                r8 = 8'($urandom());
                bm[k] = int'(r8);
            end
            load_all();
            run_check($sformatf("R5 random %0d", n), 1'b0, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule